// File: doc/BRIEF.md
# Trace-Forward Merge State Tracker

This block follows a survivor bank while it is being written and keeps the set of current trellis states whose survivor paths lead back to one guessed terminating state. The guess is the state with the smallest path metric at the end of the previous block. The block loads that state as the only member of a 64-bit membership vector. On each trellis step, the vector is rebuilt from the step's add-compare-select decisions. All 64 next bits are computed in parallel, one step per cycle.

When the bank is closed, the memory controller asks whether its traceback starting state is in the set. On a hit, the controller can skip the traceback through that bank and use the guessed state directly, which the block reports beside the hit flag. If the reported state is used as the seed for the following block, hits can chain across banks.

Top module: `tf_merge_tracker`

## Requirements
- R1: While reset is held and after it is released, hit and hit_state read 0 and the membership set is empty, so any query returns no hit until a seed is loaded.
- R2: A cycle with seed_valid high replaces the set with exactly the one state seed_state, whatever the set held before. That seed also becomes the state reported for the block.
- R3: A cycle with dec_valid high rebuilds the whole set. New bit s is the old bit at predecessor state {dec_word[s], s[5:1]}, with dec_word[s] on the most significant side. No old bit carries over except through this rule.
- R4: In a cycle with neither seed_valid nor dec_valid, the set keeps its contents.
- R5: On block_end, hit is loaded with the membership bit of query_state, taken after applying any decision word that arrives in the same cycle. hit_state is loaded with the seed of the block being closed. Both take their new values one clock after block_end.
- R6: hit and hit_state hold their values in every cycle without block_end.
- R7: Once the set is empty it stays empty until the next seed, and every query in that stretch reports no hit.
- R8: A decision word that arrives in the same cycle as seed_valid belongs to the outgoing block. It affects only a query made in that cycle, and the next block starts from the seed alone. With block_end in the same cycle, hit_state reports the outgoing seed, not the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_valid | input | 1 | Load a new guessed terminating state |
| seed_state | input | 6 | Guessed terminating state |
| dec_valid | input | 1 | Decision word valid for this trellis step |
| dec_word | input | 64 | One survivor decision bit per state |
| block_end | input | 1 | Bank complete; evaluate query_state |
| query_state | input | 6 | Traceback starting state to test |
| hit | output | 1 | Query state was a member of the set |
| hit_state | output | 6 | Seed of the block that was queried |

## Verification
Three functions can fall in the same cycle: the last decision step of a bank, the block_end query, and the seed that opens the next bank. The bench drives all three together on purpose. In one directed case, the final decision word empties the set in the query cycle. This shows that the query sees the stepped set and that hit_state reports the outgoing seed. The random phase closes most blocks together with the next seed and often feeds a hit's state back as that seed. Each outcome is judged against a bench model that applies the ordering stated in R8.

// File: rtl/tf_merge_tracker.sv
module tf_merge_tracker #(
  parameter int SW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed_valid,
  input  logic [SW-1:0]   seed_state,
  input  logic            dec_valid,
  input  logic [(1<<SW)-1:0] dec_word,
  input  logic            block_end,
  input  logic [SW-1:0]   query_state,
  output logic            hit,
  output logic [SW-1:0]   hit_state
);
  localparam int NS = 1 << SW;

  logic [NS-1:0] member;
  logic [NS-1:0] stepped;
  logic [SW-1:0] seed_q;

  for (genvar s = 0; s < NS; s++) begin : g_step
    localparam logic [SW-1:0] SV = SW'(s);
    assign stepped[s] = dec_valid ? member[{dec_word[s], SV[SW-1:1]}] : member[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      member    <= '0;
      seed_q    <= '0;
      hit       <= 1'b0;
      hit_state <= '0;
    end else begin
      if (block_end) begin
        hit       <= stepped[query_state];
        hit_state <= seed_q;
      end
      if (seed_valid) begin
        member <= '0;
        member[seed_state] <= 1'b1;
        seed_q <= seed_state;
      end else begin
        member <= stepped;
      end
    end
  end

  // R2
  seed_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |=> ($countones(member) == 1) && member[$past(seed_state)]);

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !block_end |=> $stable(hit) && $stable(hit_state));

  // R7
  empty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (member == '0) && !seed_valid |=> member == '0);

  // R7
  empty_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_end && (member == '0) |=> !hit);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_valid && !dec_valid |=> $stable(member));

  // R5
  report_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |=> hit_state == $past(seed_q));
endmodule

// File: tb/tf_merge_tracker_tb.sv
module tf_merge_tracker_tb;
  localparam int CLK_NS = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        seed_valid = 0;
  logic [5:0]  seed_state = 0;
  logic        dec_valid = 0;
  logic [63:0] dec_word = 0;
  logic        block_end = 0;
  logic [5:0]  query_state = 0;
  logic        hit;
  logic [5:0]  hit_state;

  int errors = 0;
  int checks = 0;
  logic [63:0] mset = 0;
  logic [5:0]  mseed = 0;
  logic        mhit = 0;
  logic [5:0]  mhs = 0;
  logic        done = 0;

  tf_merge_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_state(seed_state),
    .dec_valid(dec_valid), .dec_word(dec_word), .block_end(block_end),
    .query_state(query_state), .hit(hit), .hit_state(hit_state)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [63:0] step_f(input logic [63:0] st, input logic [63:0] w);
    logic [63:0] r;
    for (int s = 0; s < 64; s++) begin
      logic [5:0] sv = 6'(s);
      r[s] = st[{w[s], sv[5:1]}];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic sv, input logic [5:0] ss, input logic dv,
                      input logic [63:0] dw, input logic be, input logic [5:0] qs,
                      input string tag);
    logic [63:0] stp;
    seed_valid = sv; seed_state = ss; dec_valid = dv; dec_word = dw;
    block_end = be; query_state = qs;
    stp = dv ? step_f(mset, dw) : mset;
    if (be) begin mhit = stp[qs]; mhs = mseed; end
    if (sv) begin mset = 64'b1 << ss; mseed = ss; end else mset = stp;
    @(posedge clk); #1;
    chk({tag, " hit"}, int'(hit), int'(mhit));
    chk({tag, " hit_state"}, int'(hit_state), int'(mhs));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset hit", int'(hit), 0);
    chk("R1 reset hit_state", int'(hit_state), 0);
    rst_n = 1;
    tick(0, 0, 0, 0, 1, 6'd0, "R1 empty query");
    tick(0, 0, 0, 0, 1, 6'd35, "R7 no seed query");
    // R2/R4/R5: seed 35, idle, query it and a neighbour
    tick(1, 6'd35, 0, 0, 0, 0, "R2 seed");
    tick(0, 0, 0, 0, 0, 0, "R4 idle");
    tick(0, 0, 0, 0, 1, 6'd35, "R5 query seed");
    chk("R5 direct hit", int'(hit), 1);
    tick(0, 0, 0, 0, 1, 6'd34, "R2 non-member");
    chk("R2 direct miss", int'(hit), 0);
    // R3: all-ones decisions from 35 give members 6 and 7
    tick(0, 0, 1, '1, 0, 0, "R3 step");
    tick(0, 0, 0, 0, 1, 6'd6, "R3 member6");
    chk("R3 direct 6", int'(hit), 1);
    tick(0, 0, 0, 0, 1, 6'd7, "R3 member7");
    chk("R3 direct 7", int'(hit), 1);
    tick(0, 0, 0, 0, 1, 6'd35, "R3 old dropped");
    chk("R3 direct 35", int'(hit), 0);
    tick(0, 0, 0, 0, 0, 0, "R6 hold");
    chk("R6 hold hit", int'(hit), 0);
    // R7: all-ones again empties {6,7}
    tick(0, 0, 1, '1, 0, 0, "R7 empty step");
    tick(0, 0, 1, $urandom(), 0, 0, "R7 stay empty");
    tick(0, 0, 0, 0, 1, 6'd6, "R7 empty query");
    chk("R7 direct", int'(hit), 0);
    // R8: step empties set in the closing cycle, new seed same cycle
    tick(1, 6'd10, 0, 0, 0, 0, "R8 seed");
    tick(1, 6'd20, 1, '1, 1, 6'd10, "R8 close+seed");
    chk("R8 direct hit", int'(hit), 0);
    chk("R8 direct state", int'(hit_state), 10);
    tick(0, 0, 0, 0, 1, 6'd20, "R8 new block");
    chk("R8 new seed hit", int'(hit), 1);
    tick(1, 6'd12, 1, '1, 0, 0, "R8 seed+dec");
    tick(0, 0, 0, 0, 1, 6'd12, "R8 seed wins");
    chk("R8 seed wins direct", int'(hit), 1);

    // random blocks, closing with next seed, chaining hit states
    for (int b = 0; b < 400; b++) begin
      int nst = 1 + ($urandom % 12);
      for (int k = 0; k < nst; k++) begin
        if (($urandom % 4) == 0) tick(0, 0, 0, 0, 0, 0, "R4 rand idle");
        else tick(0, 0, 1, {$urandom, $urandom}, 0, 0, "R3 rand step");
      end
      begin
        logic [63:0] w;
        logic [63:0] stp;
        logic [5:0] q;
        logic [5:0] ns;
        logic dv;
        w = {$urandom, $urandom};
        dv = $urandom % 2;
        stp = dv ? step_f(mset, w) : mset;
        q = 6'($urandom);
        if (stp != 0 && ($urandom % 2)) begin
          for (int i = 0; i < 64; i++)
            if (stp[6'(q + 6'(i))]) begin q = 6'(q + 6'(i)); break; end
        end
        ns = (mhit && ($urandom % 2)) ? mhs : 6'($urandom);
        if ($urandom % 4 == 0) begin
          tick(0, 0, dv, w, 1, q, "R5 rand close");
          tick(1, ns, 0, 0, 0, 0, "R2 rand seed");
        end else begin
          tick(1, ns, dv, w, 1, q, "R8 rand close+seed");
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule